// File: doc/BRIEF.md
# Reference Clock Rate Auto-Detector

This block works out, by measurement alone, which power-of-two relation holds between a reference clock and a prescaled copy of a synthesized output clock. No configuration input names the reference frequency. The block counts prescaled-output cycles across a fixed number of reference cycles. It rounds the ratio to the nearest power of two and accepts it only if the measurement sits close enough to that value. It also requires the ratio to be legal for the output band chosen by a range-select bit. The result is a divider exponent for a neighbouring lock detector, with a flag that says whether the exponent may be trusted.

The reference clock may be synchronous or asynchronous to the output clock, with any phase. The window is timed in the reference domain as a toggle that flips once per window. That toggle is synchronized into the output-clock domain, where the cycles are counted and classified. The reported exponent becomes valid only after two measurements in a row agree. Once valid, it is held against a single stray measurement.

Top module: `refclk_ratio_detect`

## Requirements
- R1: While `rst_n` is low, `ratio_valid` is 0 and `ratio_exp` is 0.
- R2: With `range_sel` = 1, the accepted output-to-reference ratios are 1, 2, 4, 8 and 16, reported as `ratio_exp` = log2(ratio), that is 0 to 4.
- R3: With `range_sel` = 0, the accepted ratios are 4, 8, 16, 32 and 64, reported as `ratio_exp` = 2 to 6.
- R4: A measurement counts `out_clk` cycles between two window boundaries that lie 2^WIN_LOG2 reference cycles apart. It matches exponent k when the count lies within 3/4 to 5/4 of 2^k x 2^WIN_LOG2, both ends included. A ratio that matches no k (for example 11 or 1.4) is rejected, and `ratio_valid` stays or goes low.
- R5: A ratio that is a power of two but outside the set for the current `range_sel` is rejected in the same way.
- R6: After reset or a restart, the first window boundary only starts counting. `ratio_valid` rises only at a window end, when two consecutive accepted measurements carry the same exponent.
- R7: A change of `range_sel` restarts detection. `ratio_valid` goes low within a few `out_clk` cycles, and earlier measurements are discarded.
- R8: While valid, one measurement that differs from the held exponent changes nothing. After two consecutive differing measurements, the held exponent switches with the flag kept high if both carry the same accepted exponent. Otherwise `ratio_valid` drops.
- R9: The result does not depend on the phase of `ref_clk` relative to `out_clk`, and it tolerates a few percent of frequency error.
- R10: `ratio_exp` changes only in the cycle after a window boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock that times the measurement window |
| out_clk | input | 1 | Prescaled synthesized output clock; all results are in this domain |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| range_sel | input | 1 | Output band select: 0 allows ratios 4..64, 1 allows ratios 1..16 |
| ratio_exp | output | 3 | Detected divider exponent log2(out/ref) |
| ratio_valid | output | 1 | High while `ratio_exp` is trusted |

## Verification
The block is driven with every legal power-of-two ratio in both bands. These stimuli show that the rounding and the band mask pick the right exponent. Non-power ratios and ratios near the ±1/4 edge test the acceptance window. Legal powers in the wrong band show that the mask rejects. A ratio step timed in mid-window shows that a single disagreeing measurement is held off. Toggling the range bit while locked shows the restart, and randomly jittered periods with random phase show that the result does not depend on phase.

// File: rtl/refclk_ratio_detect.sv
`timescale 1ps/1ps
module refclk_ratio_detect #(
  parameter int WIN_LOG2 = 8
) (
  input  logic       ref_clk,
  input  logic       out_clk,
  input  logic       rst_n,
  input  logic       range_sel,
  output logic [2:0] ratio_exp,
  output logic       ratio_valid
);
  localparam int CNT_W = WIN_LOG2 + 7;
  localparam int NEXP  = 7;

  // reference domain: one toggle per window
  logic [WIN_LOG2-1:0] ref_cnt;
  logic                ref_tog;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      ref_cnt <= '0;
      ref_tog <= 1'b0;
    end else begin
      ref_cnt <= ref_cnt + 1'b1;
      if (&ref_cnt) ref_tog <= ~ref_tog;
    end

  // output domain
  logic [2:0]       tog_sy;
  logic [1:0]       rs_sy;
  logic             rs_q, armed, prev_ok, miss;
  logic [2:0]       prev_k;
  logic [CNT_W-1:0] cnt;
  logic [NEXP-1:0]  hit, allow;
  logic             m_ok;
  logic [2:0]       m_k;

  wire win_done = tog_sy[2] ^ tog_sy[1];
  wire rs_chg   = rs_sy[1] ^ rs_q;

  for (genvar k = 0; k < NEXP; k++) begin : g_band
    localparam logic [CNT_W-1:0] LO = CNT_W'(3 << (k + WIN_LOG2 - 2));
    localparam logic [CNT_W-1:0] HI = CNT_W'(5 << (k + WIN_LOG2 - 2));
    assign hit[k] = (cnt >= LO) && (cnt <= HI);
  end

  assign allow = rs_q ? 7'b0011111 : 7'b1111100;

  always_comb begin
    m_ok = 1'b0;
    m_k  = 3'd0;
    for (int k = 0; k < NEXP; k++)
      if (hit[k] && allow[k]) begin
        m_ok = 1'b1;
        m_k  = 3'(k);
      end
  end

  wire same_as_prev = m_ok && prev_ok && (prev_k == m_k);

  always_ff @(posedge out_clk or negedge rst_n)
    if (!rst_n) begin
      tog_sy      <= '0;
      rs_sy       <= '0;
      rs_q        <= 1'b0;
      cnt         <= '0;
      armed       <= 1'b0;
      prev_ok     <= 1'b0;
      prev_k      <= '0;
      miss        <= 1'b0;
      ratio_valid <= 1'b0;
      ratio_exp   <= '0;
    end else begin
      tog_sy <= {tog_sy[1:0], ref_tog};
      rs_sy  <= {rs_sy[0], range_sel};
      rs_q   <= rs_sy[1];
      if (win_done)   cnt <= CNT_W'(1);
      else if (~&cnt) cnt <= cnt + 1'b1;
      if (rs_chg) begin
        armed       <= 1'b0;
        prev_ok     <= 1'b0;
        miss        <= 1'b0;
        ratio_valid <= 1'b0;
      end else if (win_done) begin
        armed <= 1'b1;
        if (armed) begin
          prev_ok <= m_ok;
          prev_k  <= m_k;
          if (!ratio_valid) begin
            if (same_as_prev) begin
              ratio_valid <= 1'b1;
              ratio_exp   <= m_k;
            end
          end else if (m_ok && m_k == ratio_exp) begin
            miss <= 1'b0;
          end else if (!miss) begin
            miss <= 1'b1;
          end else begin
            miss <= 1'b0;
            if (same_as_prev) ratio_exp <= m_k;
            else              ratio_valid <= 1'b0;
          end
        end
      end
    end

  p_restart_drops_valid_r7: assert property (@(posedge out_clk) disable iff (!rst_n)
    rs_chg |=> !ratio_valid);
  p_band_high_exp_r2: assert property (@(posedge out_clk) disable iff (!rst_n)
    (ratio_valid && rs_q) |-> (ratio_exp <= 3'd4));
  p_band_low_exp_r3: assert property (@(posedge out_clk) disable iff (!rst_n)
    (ratio_valid && !rs_q) |-> (ratio_exp >= 3'd2 && ratio_exp <= 3'd6));
  p_exp_at_window_r10: assert property (@(posedge out_clk) disable iff (!rst_n)
    !win_done |=> $stable(ratio_exp));
  p_valid_rise_at_window_r6: assert property (@(posedge out_clk) disable iff (!rst_n)
    $rose(ratio_valid) |-> ($past(win_done) && $past(armed)));
  p_held_single_miss_r8: assert property (@(posedge out_clk) disable iff (!rst_n)
    (ratio_valid && !miss && win_done && !rs_chg) |=> ratio_valid);
endmodule

// File: tb/refclk_ratio_detect_tb.sv
`timescale 1ps/1ps
module refclk_ratio_detect_tb;
  localparam int REF_PER = 12800;
  localparam int WLOG    = 6;
  localparam int WIN     = 1 << WLOG;

  logic ref_clk = 1'b0, out_clk = 1'b0, rst_n = 1'b0, range_sel = 1'b0;
  logic [2:0] ratio_exp;
  logic ratio_valid;
  int out_half = REF_PER / 16;
  int checks = 0, errors = 0;

  refclk_ratio_detect #(.WIN_LOG2(WLOG)) u_dut (
    .ref_clk(ref_clk), .out_clk(out_clk), .rst_n(rst_n),
    .range_sel(range_sel), .ratio_exp(ratio_exp), .ratio_valid(ratio_valid));

  always #(REF_PER/2) ref_clk = ~ref_clk;
  always begin
    #(out_half);
    out_clk = ~out_clk;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void expect_of(input int half, input logic rs, output int ok, output int k);
    real r;
    r  = real'(REF_PER) / (2.0 * real'(half));
    ok = 0;
    k  = 0;
    for (int i = 0; i < 7; i++)
      if (r >= 0.75 * real'(1 << i) && r <= 1.25 * real'(1 << i) &&
          ((rs && i <= 4) || (!rs && i >= 2))) begin
        ok = 1;
        k  = i;
      end
  endfunction

  task automatic set_ratio(input real r, input int jit_pm);
    real f;
    f = 1.0 + real'(jit_pm) / 1000.0;
    out_half = int'(real'(REF_PER) / (2.0 * r * f));
  endtask

  task automatic settle_check(input string req);
    int ok, k;
    repeat (4 * WIN) @(posedge ref_clk);
    @(negedge out_clk);
    expect_of(out_half, range_sel, ok, k);
    check({req, " valid"}, int'(ratio_valid), ok);
    if (ok == 1) check({req, " exp"}, int'(ratio_exp), k);
  endtask

  task automatic run_case(input logic rs, input real r, input string req);
    range_sel = rs;
    set_ratio(r, 0);
    settle_check(req);
  endtask

  initial begin
    #(REF_PER * 30000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    set_ratio(8.0, 0);
    repeat (5) @(posedge ref_clk);
    @(negedge out_clk);
    check("R1 valid in reset", int'(ratio_valid), 0);
    check("R1 exp in reset", int'(ratio_exp), 0);
    rst_n = 1'b1;
    // first boundary only arms; one measurement is not enough (R6)
    repeat (WIN * 2 + WIN / 2) @(posedge ref_clk);
    @(negedge out_clk);
    check("R6 not valid after one measurement", int'(ratio_valid), 0);
    repeat (WIN) @(posedge ref_clk);
    @(negedge out_clk);
    check("R6 valid after two matches", int'(ratio_valid), 1);
    check("R3 exp ratio 8", int'(ratio_exp), 3);

    run_case(1'b0, 4.0,  "R3 ratio 4");
    run_case(1'b0, 16.0, "R3 ratio 16");
    run_case(1'b0, 32.0, "R3 ratio 32");
    run_case(1'b0, 64.0, "R3 ratio 64");
    run_case(1'b0, 8.0,  "R3 ratio 8 again");

    // range change restarts (R7)
    range_sel = 1'b1;
    repeat (12) @(negedge out_clk);
    check("R7 restart clears valid", int'(ratio_valid), 0);
    settle_check("R2 ratio 8 after restart");

    run_case(1'b1, 1.0,  "R2 ratio 1");
    run_case(1'b1, 2.0,  "R2 ratio 2");
    run_case(1'b1, 4.0,  "R2 ratio 4");
    run_case(1'b1, 16.0, "R2 ratio 16");
    run_case(1'b1, 32.0, "R5 ratio 32 in high band");
    run_case(1'b0, 2.0,  "R5 ratio 2 in low band");
    run_case(1'b0, 11.0, "R4 ratio 11");
    run_case(1'b1, 1.4,  "R4 ratio 1.4");
    run_case(1'b0, 9.6,  "R4 ratio 9.6 near edge");
    run_case(1'b0, 12.8, "R4 ratio 12.8 near edge");

    // hold against a single stray measurement (R8)
    run_case(1'b0, 8.0, "R8 lock at 8");
    set_ratio(16.0, 0);
    repeat (WIN / 2) @(posedge ref_clk);
    @(negedge out_clk);
    check("R8 held exp after step", int'(ratio_exp), 3);
    check("R8 held valid after step", int'(ratio_valid), 1);
    settle_check("R8 switched to 16");

    // random ratios, jitter and phase (R9)
    for (int n = 0; n < 8; n++) begin
      logic rs;
      int   e;
      rs = 1'($urandom % 2);
      e  = int'($urandom % 5);
      range_sel = rs;
      set_ratio(real'(1 << e), int'($urandom % 61) - 30);
      #($urandom % REF_PER);
      settle_check("R9 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule